// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Controller

This block adds enhanced-mode address and data transfers to a byte-wide printer port. A host issues single register accesses over a small request/done interface. Offsets 0 to 2 hold the usual data latch, status view and control register. Offsets 3 and 4 start an address cycle or a data cycle on the peripheral side. Each transfer goes ahead only when the stored control byte holds the exact pattern for its direction. Otherwise the write is discarded and the read returns all ones.

An accepted transfer is run by a byte handshake engine. The engine raises an address or data strobe, then waits for the peripheral's acknowledge for at most a programmable number of cycles. An access at offset 4 may be 8, 16 or 32 bits wide; it is split into byte cycles, lowest byte first. When a byte cycle expires, the rest of the access is abandoned and a sticky timeout flag is set. Status reads show that flag in bit 0, and writing a one to that bit clears it. Writes that would leave the data latch or the control register unchanged produce no update pulse toward the port.

Top module: `epp_port_ctrl`

## Requirements
- R1: A qualified access at offset 3 runs an address cycle on `addr_stb`, and one at offset 4 runs a data cycle on `data_stb`; a written byte is placed on `pd_out`. Offsets 5 to 7 read as all ones, and writes to them have no effect.
- R2: A write at offset 3 or 4 runs only if control bits {5 direction, 3 select, 2 init, 1 linefeed, 0 strobe} equal 0b00100 (control & 0x2F == 0x04).
- R3: A read at offset 3 or 4 runs only if the same bits equal 0b10100 (control & 0x2F == 0x24).
- R4: When the control pattern does not qualify, a write causes no strobe and no transfer, and a read returns 0xFFFFFFFF.
- R5: A byte cycle holds exactly one strobe high, with `xfer_wr` high for writes. It ends with success in the cycle the sampled `epp_wait` is high, and a read captures `pd_in` at that edge.
- R6: If `epp_wait` does not arrive, the strobe stays high for exactly `tmo_limit` cycles (a limit of 0 behaves as 1). The cycle then aborts, and a sticky timeout flag is set.
- R7: A status read (offset 1) returns `st_in` in bits 7:1 and the timeout flag in bit 0. A status write with bit 0 set clears the flag; with bit 0 clear, the flag is left unchanged.
- R8: At offset 4, size code 0/1/2 (byte/half/word; 3 behaves as word) moves 1/2/4 bytes in little-endian order, lowest byte first. Offset 3 always moves one byte. On reads, the bits above the access width read as ones.
- R9: After the first failed byte of a multi-byte access, the remaining bytes are skipped, and unread bytes read as 0xFF.
- R10: A write to offset 0 or 2 that leaves the stored value unchanged produces no `pd_update` or `ctl_update` pulse. A changing write produces exactly one.
- R11: The control register stores the written byte with bits 7:6 forced to one. It resets to 0xCC, and the data latch resets to 0xFF. An offset 0 read returns the latch when the direction bit is 0 and `pd_in` when it is 1.
- R12: Reset clears the timeout flag and abandons any cycle in progress, dropping the strobes and `host_busy`. A register access (offsets 0–2, 5–7, or a refused transfer) pulses `host_done` on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle access request, taken when `host_busy` is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Register offset |
| host_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| host_wdata | input | 32 | Write data, little-endian |
| tmo_limit | input | TMO_W | Acknowledge wait limit in cycles |
| st_in | input | 7 | Peripheral status lines for status bits 7:1 |
| pd_in | input | 8 | Port data bus input |
| epp_wait | input | 1 | Peripheral acknowledge |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with `host_done` |
| host_busy | output | 1 | Multi-byte transfer in progress |
| pd_out | output | 8 | Port data bus output |
| pd_oe | output | 1 | Port data bus drive enable |
| pd_update | output | 1 | Pulse when the data latch changes |
| ctl_out | output | 8 | Stored control byte |
| ctl_update | output | 1 | Pulse when the control byte changes |
| addr_stb | output | 1 | Address cycle strobe |
| data_stb | output | 1 | Data cycle strobe |
| xfer_wr | output | 1 | Direction of the running cycle, 1 = write |

## Verification
A corrupted control byte shows up on the next transfer. It either lets a refused transfer through (a strobe rises within one cycle) or turns a legal read into all ones at `host_done`. A wrong wait counter shows as a strobe width that differs from `tmo_limit` by the first failed byte. A lane index or lane buffer fault shows as swapped or missing bytes, in the peripheral's write log or in `host_rdata` of the same access. A timeout flag that fails to stick or to clear is visible at the next status read.

// File: rtl/epp_port_pkg.sv
package epp_port_pkg;
   localparam logic [2:0] OFF_DATA = 3'd0;
   localparam logic [2:0] OFF_STAT = 3'd1;
   localparam logic [2:0] OFF_CTRL = 3'd2;
   localparam logic [2:0] OFF_EADR = 3'd3;
   localparam logic [2:0] OFF_EDAT = 3'd4;

   localparam int CB_DIR = 5;

   localparam logic [7:0] CTL_QMASK = 8'h2F;
   localparam logic [7:0] CTL_QWR   = 8'h04;
   localparam logic [7:0] CTL_QRD   = 8'h24;
   localparam logic [7:0] CTL_RST   = 8'hCC;
   localparam logic [7:0] CTL_FIX   = 8'hC0;

   typedef enum logic [1:0] {
      XS_BYTE = 2'd0,
      XS_HALF = 2'd1,
      XS_WORD = 2'd2,
      XS_WIDE = 2'd3
   } xfer_size_e;
endpackage

// File: rtl/epp_qual.sv
module epp_qual
   import epp_port_pkg::*;
(
   input  logic [7:0] ctl,
   output logic       wr_ok,
   output logic       rd_ok
);
   logic [7:0] sig;
   assign sig   = ctl & CTL_QMASK;
   assign wr_ok = (sig == CTL_QWR);
   assign rd_ok = (sig == CTL_QRD);
endmodule

// File: rtl/epp_byte_engine.sv
module epp_byte_engine #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_addr,
   input  logic             start_wr,
   input  logic [7:0]       start_byte,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic             epp_wait,
   input  logic [7:0]       pd_in,
   output logic             addr_stb,
   output logic             data_stb,
   output logic             xfer_wr,
   output logic             drive_en,
   output logic [7:0]       drive_byte,
   output logic             fin,
   output logic             fin_ok,
   output logic [7:0]       fin_byte
);
   logic             act_q, addr_q, wr_q, fin_q, ok_q;
   logic [7:0]       byte_q, rbyte_q;
   logic [TMO_W-1:0] cnt_q;
   logic [TMO_W-1:0] lim_eff;
   logic [TMO_W:0]   cnt_nxt;

   assign lim_eff = (tmo_limit == '0) ? TMO_W'(1) : tmo_limit;
   assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         addr_q  <= 1'b0;
         wr_q    <= 1'b0;
         fin_q   <= 1'b0;
         ok_q    <= 1'b0;
         byte_q  <= 8'h00;
         rbyte_q <= 8'hFF;
         cnt_q   <= '0;
      end else begin
         fin_q <= 1'b0;
         if (!act_q) begin
            if (start) begin
               act_q   <= 1'b1;
               addr_q  <= start_addr;
               wr_q    <= start_wr;
               byte_q  <= start_byte;
               cnt_q   <= '0;
            end
         end else if (epp_wait) begin
            act_q <= 1'b0;
            fin_q <= 1'b1;
            ok_q  <= 1'b1;
            if (!wr_q) rbyte_q <= pd_in;
         end else if (cnt_nxt >= {1'b0, lim_eff}) begin
            act_q <= 1'b0;
            fin_q <= 1'b1;
            ok_q  <= 1'b0;
         end else begin
            cnt_q <= cnt_nxt[TMO_W-1:0];
         end
      end
   end

   assign addr_stb   = act_q & addr_q;
   assign data_stb   = act_q & ~addr_q;
   assign xfer_wr    = act_q & wr_q;
   assign drive_en   = act_q & wr_q;
   assign drive_byte = byte_q;
   assign fin        = fin_q;
   assign fin_ok     = ok_q;
   assign fin_byte   = rbyte_q;

   // R5: never both strobes
   a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr_stb && data_stb));
   // R6: wait counter never reaches the limit while strobing
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> ({1'b0, cnt_q} < {1'b0, lim_eff}));
   // R5: completion releases the strobe
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> !(addr_stb || data_stb));
endmodule

// File: rtl/epp_seq.sv
module epp_seq #(
   parameter int LANES = 4,
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic               launch_addr,
   input  logic               launch_wr,
   input  logic [IDX_W-1:0]   launch_last,
   input  logic [LANES*8-1:0] launch_wdata,
   input  logic               eng_fin,
   input  logic               eng_ok,
   input  logic [7:0]         eng_rbyte,
   output logic               eng_start,
   output logic               eng_addr,
   output logic               eng_wr,
   output logic [7:0]         eng_wbyte,
   output logic               busy,
   output logic               done,
   output logic               failed,
   output logic [LANES*8-1:0] rdata
);
   logic               busy_q, go_q, addr_q, wr_q, done_q, fail_q;
   logic [IDX_W-1:0]   idx_q, last_q;
   logic [LANES*8-1:0] wdata_q;
   logic [7:0]         rbuf  [LANES];
   logic [7:0]         wlane [LANES];
   logic               take;

   assign take = launch && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         go_q    <= 1'b0;
         addr_q  <= 1'b0;
         wr_q    <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
         idx_q   <= '0;
         last_q  <= '0;
         wdata_q <= '0;
      end else begin
         go_q   <= 1'b0;
         done_q <= 1'b0;
         fail_q <= 1'b0;
         if (!busy_q) begin
            if (launch) begin
               busy_q  <= 1'b1;
               go_q    <= 1'b1;
               idx_q   <= '0;
               last_q  <= launch_last;
               addr_q  <= launch_addr;
               wr_q    <= launch_wr;
               wdata_q <= launch_wdata;
            end
         end else if (eng_fin) begin
            if (eng_ok && (idx_q != last_q)) begin
               idx_q <= idx_q + 1'b1;
               go_q  <= 1'b1;
            end else begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               fail_q <= !eng_ok;
            end
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rbuf[g] <= 8'hFF;
         else if (take)
            rbuf[g] <= 8'hFF;
         else if (busy_q && eng_fin && eng_ok && !wr_q && (idx_q == IDX_W'(g)))
            rbuf[g] <= eng_rbyte;
      end
      assign wlane[g]         = wdata_q[g*8 +: 8];
      assign rdata[g*8 +: 8]  = rbuf[g];
   end

   assign eng_start = go_q;
   assign eng_addr  = addr_q;
   assign eng_wr    = wr_q;
   assign eng_wbyte = wlane[idx_q];
   assign busy      = busy_q;
   assign done      = done_q;
   assign failed    = fail_q;

   // R9: a failed byte ends the access without another byte cycle
   a_r9_stop_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && eng_fin && !eng_ok) |=> (!go_q && !busy_q && fail_q));
   // R8: lane index stays within the access width
   a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (idx_q <= last_q));
endmodule

// File: rtl/epp_port_ctrl.sv
module epp_port_ctrl
   import epp_port_pkg::*;
#(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_req,
   input  logic             host_we,
   input  logic [2:0]       host_off,
   input  logic [1:0]       host_size,
   input  logic [31:0]      host_wdata,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic [7:1]       st_in,
   input  logic [7:0]       pd_in,
   input  logic             epp_wait,
   output logic             host_done,
   output logic [31:0]      host_rdata,
   output logic             host_busy,
   output logic [7:0]       pd_out,
   output logic             pd_oe,
   output logic             pd_update,
   output logic [7:0]       ctl_out,
   output logic             ctl_update,
   output logic             addr_stb,
   output logic             data_stb,
   output logic             xfer_wr
);
   localparam int LANES = 4;
   localparam int IDX_W = $clog2(LANES);

   if (TMO_W < 2 || TMO_W > 31) begin : g_bad_tmo
      $error("epp_port_ctrl: TMO_W out of range");
   end

   logic [7:0]  data_q, ctl_q, ctl_new;
   logic        tmo_q, rdone_q, pupd_q, cupd_q;
   logic [31:0] rrd_q, rd_mux;
   logic        wr_ok, rd_ok, is_epp, qual, acc, launch;
   logic [IDX_W-1:0] last_lane;
   logic        sq_busy, sq_done, sq_fail;
   logic [31:0] sq_rdata;
   logic        e_start, e_addr, e_wr, e_fin, e_ok, e_drv;
   logic [7:0]  e_wbyte, e_rbyte, e_dbyte;
   logic        clr_req;

   epp_qual u_qual (.ctl(ctl_q), .wr_ok(wr_ok), .rd_ok(rd_ok));

   assign is_epp  = (host_off == OFF_EADR) || (host_off == OFF_EDAT);
   assign qual    = host_we ? wr_ok : rd_ok;
   assign acc     = host_req && !sq_busy;
   assign launch  = acc && is_epp && qual;
   assign ctl_new = host_wdata[7:0] | CTL_FIX;
   assign clr_req = acc && host_we && (host_off == OFF_STAT) && host_wdata[0];

   always_comb begin
      if (host_off == OFF_EADR) last_lane = '0;
      else begin
         case (xfer_size_e'(host_size))
            XS_BYTE: last_lane = IDX_W'(0);
            XS_HALF: last_lane = IDX_W'(1);
            default: last_lane = IDX_W'(LANES - 1);
         endcase
      end
   end

   always_comb begin
      rd_mux = '1;
      if (!host_we) begin
         case (host_off)
            OFF_DATA: rd_mux[7:0] = ctl_q[CB_DIR] ? pd_in : data_q;
            OFF_STAT: rd_mux[7:0] = {st_in, tmo_q};
            OFF_CTRL: rd_mux[7:0] = ctl_q;
            default:  rd_mux[7:0] = 8'hFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= 8'hFF;
         ctl_q   <= CTL_RST;
         tmo_q   <= 1'b0;
         rdone_q <= 1'b0;
         rrd_q   <= '1;
         pupd_q  <= 1'b0;
         cupd_q  <= 1'b0;
      end else begin
         rdone_q <= 1'b0;
         pupd_q  <= 1'b0;
         cupd_q  <= 1'b0;
         if (sq_done && sq_fail) tmo_q <= 1'b1;
         if (acc && !launch) begin
            rdone_q <= 1'b1;
            rrd_q   <= rd_mux;
            if (host_we) begin
               if (host_off == OFF_DATA && host_wdata[7:0] != data_q) begin
                  data_q <= host_wdata[7:0];
                  pupd_q <= 1'b1;
               end
               if (host_off == OFF_CTRL && ctl_new != ctl_q) begin
                  ctl_q  <= ctl_new;
                  cupd_q <= 1'b1;
               end
               if (clr_req) tmo_q <= 1'b0;
            end
         end
      end
   end

   epp_seq #(.LANES(LANES)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .launch(launch), .launch_addr(host_off == OFF_EADR), .launch_wr(host_we),
      .launch_last(last_lane), .launch_wdata(host_wdata),
      .eng_fin(e_fin), .eng_ok(e_ok), .eng_rbyte(e_rbyte),
      .eng_start(e_start), .eng_addr(e_addr), .eng_wr(e_wr), .eng_wbyte(e_wbyte),
      .busy(sq_busy), .done(sq_done), .failed(sq_fail), .rdata(sq_rdata)
   );

   epp_byte_engine #(.TMO_W(TMO_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .start(e_start), .start_addr(e_addr), .start_wr(e_wr), .start_byte(e_wbyte),
      .tmo_limit(tmo_limit), .epp_wait(epp_wait), .pd_in(pd_in),
      .addr_stb(addr_stb), .data_stb(data_stb), .xfer_wr(xfer_wr),
      .drive_en(e_drv), .drive_byte(e_dbyte),
      .fin(e_fin), .fin_ok(e_ok), .fin_byte(e_rbyte)
   );

   assign host_done  = rdone_q | sq_done;
   assign host_rdata = sq_done ? sq_rdata : rrd_q;
   assign host_busy  = sq_busy;
   assign pd_out     = e_drv ? e_dbyte : data_q;
   assign pd_oe      = (addr_stb | data_stb) ? e_drv : !ctl_q[CB_DIR];
   assign pd_update  = pupd_q;
   assign ctl_out    = ctl_q;
   assign ctl_update = cupd_q;

   // R4: refused transfers never strobe
   a_r4_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && is_epp && !qual) |=> !(addr_stb || data_stb));
   // R7: write-one clears the flag
   a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> !tmo_q);
   // R6: flag is sticky until cleared
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_q && !clr_req) |=> tmo_q);
   // R10: repeated data value produces no update pulse
   a_r10_same_data: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && host_we && host_off == OFF_DATA && host_wdata[7:0] == data_q) |=> !pd_update);
   // R12: register accesses complete on the next cycle
   a_r12_reg_done: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !is_epp) |=> host_done);
endmodule

// File: tb/epp_port_ctrl_bench.sv
module epp_port_ctrl_bench;
   localparam int TMO_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_req = 1'b0, host_we = 1'b0;
   logic [2:0] host_off = '0;
   logic [1:0] host_size = '0;
   logic [31:0] host_wdata = '0;
   logic [TMO_W-1:0] tmo_limit = 16'd5;
   logic [7:1] st_in = 7'b0111100;
   logic [7:0] pd_in;
   logic epp_wait;
   logic host_done, host_busy, pd_oe, pd_update, ctl_update, addr_stb, data_stb, xfer_wr;
   logic [31:0] host_rdata;
   logic [7:0] pd_out, ctl_out;

   always #5 clk = ~clk;

   epp_port_ctrl #(.TMO_W(TMO_W)) u_epp_port_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
      .tmo_limit(tmo_limit), .st_in(st_in), .pd_in(pd_in), .epp_wait(epp_wait),
      .host_done(host_done), .host_rdata(host_rdata), .host_busy(host_busy),
      .pd_out(pd_out), .pd_oe(pd_oe), .pd_update(pd_update), .ctl_out(ctl_out),
      .ctl_update(ctl_update), .addr_stb(addr_stb), .data_stb(data_stb), .xfer_wr(xfer_wr)
   );

   // peripheral model
   int ack_limit = 1000000;
   int dly = 0;
   int acked = 0, scnt = 0, stb_cyc = 0, log_n = 0, pupd_n = 0, cupd_n = 0;
   logic [7:0] rd_cnt = 8'h00;
   logic [8:0] log_mem [64];

   assign epp_wait = (addr_stb | data_stb) && (acked < ack_limit) && (scnt >= dly);
   assign pd_in    = 8'hA0 + rd_cnt;

   always @(posedge clk) begin
      if (pd_update) pupd_n <= pupd_n + 1;
      if (ctl_update) cupd_n <= cupd_n + 1;
      if (addr_stb | data_stb) begin
         stb_cyc <= stb_cyc + 1;
         if (epp_wait) begin
            scnt  <= 0;
            acked <= acked + 1;
            if (xfer_wr) begin
               log_mem[log_n[5:0]] <= {addr_stb, pd_out};
               log_n <= log_n + 1;
            end else rd_cnt <= rd_cnt + 8'd1;
         end else scnt <= scnt + 1;
      end else scnt <= 0;
   end

   int checks = 0, fails = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic we, input logic [2:0] off, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_off = off; host_size = sz; host_wdata = wd;
      @(negedge clk);
      host_req = 1'b0;
      rd = '1;
      for (int k = 0; k < 5000; k++) begin
         if (host_done) begin
            rd = host_rdata;
            break;
         end
         @(negedge clk);
      end
   endtask

   // {chk, we, off, size, wdata, expected}
   localparam int NV = 19;
   localparam logic [70:0] VEC [NV] = '{
      {1'b1, 1'b0, 3'd2, 2'd0, 32'h0,        32'hFFFFFFCC},
      {1'b1, 1'b0, 3'd0, 2'd0, 32'h0,        32'hFFFFFFFF},
      {1'b0, 1'b1, 3'd2, 2'd0, 32'h04,       32'h0},
      {1'b1, 1'b0, 3'd2, 2'd0, 32'h0,        32'hFFFFFFC4},
      {1'b0, 1'b1, 3'd0, 2'd0, 32'h5A,       32'h0},
      {1'b1, 1'b0, 3'd0, 2'd0, 32'h0,        32'hFFFFFF5A},
      {1'b0, 1'b1, 3'd3, 2'd0, 32'h31,       32'h0},
      {1'b0, 1'b1, 3'd4, 2'd2, 32'h44332211, 32'h0},
      {1'b1, 1'b0, 3'd1, 2'd0, 32'h0,        32'hFFFFFF78},
      {1'b1, 1'b0, 3'd4, 2'd0, 32'h0,        32'hFFFFFFFF},
      {1'b1, 1'b0, 3'd6, 2'd0, 32'h0,        32'hFFFFFFFF},
      {1'b0, 1'b1, 3'd2, 2'd0, 32'h24,       32'h0},
      {1'b1, 1'b0, 3'd4, 2'd1, 32'h0,        32'hFFFFA1A0},
      {1'b1, 1'b0, 3'd3, 2'd2, 32'h0,        32'hFFFFFFA2},
      {1'b0, 1'b1, 3'd4, 2'd0, 32'h99,       32'h0},
      {1'b1, 1'b0, 3'd0, 2'd0, 32'h0,        32'hFFFFFFA3},
      {1'b0, 1'b1, 3'd2, 2'd0, 32'h0C,       32'h0},
      {1'b0, 1'b1, 3'd4, 2'd0, 32'h77,       32'h0},
      {1'b1, 1'b0, 3'd2, 2'd0, 32'h0,        32'hFFFFFFCC}
   };

   function automatic string vtag(input int i);
      case (i)
         8:       return "R7";
         9:       return "R3";
         10:      return "R1";
         12, 13:  return "R8";
         default: return "R11";
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      if (!finished) $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int sc0, l0, p0, c0;
      logic [7:0] r0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 / R11 reset state
      chk("R12", {28'h0, host_done, host_busy, addr_stb, data_stb}, 32'h0);
      chk("R11", {23'h0, pd_oe, pd_out}, 32'h1FF);
      chk("R11", {24'h0, ctl_out}, 32'hCC);

      for (int i = 0; i < NV; i++) begin
         acc(VEC[i][69], VEC[i][68:66], VEC[i][65:64], VEC[i][63:32], rd);
         if (VEC[i][70]) chk(vtag(i), rd, VEC[i][31:0]);
      end
      // R4 / R2: refused writes left no trace; R1 / R8 byte order and cycle kind
      chk("R4", log_n, 5);
      chk("R1", {23'h0, log_mem[0]}, {23'h0, 9'h131});
      chk("R8", {log_mem[1], log_mem[2], log_mem[3], log_mem[4]}, {9'h011, 9'h022, 9'h033, 9'h044});
      chk("R10", pupd_n, 1);
      chk("R10", cupd_n, 3);

      // R10 repeat suppression
      p0 = pupd_n; c0 = cupd_n;
      acc(1'b1, 3'd2, 2'd0, 32'h0C, rd);
      acc(1'b1, 3'd0, 2'd0, 32'h5A, rd);
      @(negedge clk);
      chk("R10", pupd_n - p0, 0);
      chk("R10", cupd_n - c0, 0);
      acc(1'b1, 3'd0, 2'd0, 32'h5B, rd);
      @(negedge clk);
      chk("R10", pupd_n - p0, 1);

      // R6 timeout and R7 flag handling
      acc(1'b1, 3'd2, 2'd0, 32'h04, rd);
      ack_limit = acked;
      sc0 = stb_cyc;
      acc(1'b1, 3'd3, 2'd0, 32'h10, rd);
      chk("R6", stb_cyc - sc0, 5);
      acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
      chk("R6", rd, 32'hFFFFFF79);
      acc(1'b1, 3'd1, 2'd0, 32'h00, rd);
      acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
      chk("R7", rd, 32'hFFFFFF79);
      acc(1'b1, 3'd1, 2'd0, 32'h01, rd);
      acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
      chk("R7", rd, 32'hFFFFFF78);

      // R6 zero limit behaves as one
      tmo_limit = '0;
      sc0 = stb_cyc;
      acc(1'b1, 3'd3, 2'd0, 32'h12, rd);
      chk("R6", stb_cyc - sc0, 1);
      acc(1'b1, 3'd1, 2'd0, 32'h01, rd);
      tmo_limit = 16'd5;

      // R9 partial write
      ack_limit = acked + 2;
      l0 = log_n; sc0 = stb_cyc;
      acc(1'b1, 3'd4, 2'd2, 32'hDDCCBBAA, rd);
      chk("R9", log_n - l0, 2);
      chk("R9", {14'h0, log_mem[l0], log_mem[l0+1]}, {14'h0, 9'h0AA, 9'h0BB});
      chk("R9", stb_cyc - sc0, 7);
      acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
      chk("R9", rd, 32'hFFFFFF79);
      acc(1'b1, 3'd1, 2'd0, 32'h01, rd);

      // R9 partial read
      acc(1'b1, 3'd2, 2'd0, 32'h24, rd);
      ack_limit = acked + 1;
      r0 = rd_cnt;
      acc(1'b0, 3'd4, 2'd2, 32'h0, rd);
      chk("R9", rd, {24'hFFFFFF, 8'hA0 + r0});
      acc(1'b1, 3'd1, 2'd0, 32'h01, rd);

      // R5 delayed acknowledge succeeds
      ack_limit = 1000000; dly = 3;
      r0 = rd_cnt; sc0 = stb_cyc;
      acc(1'b0, 3'd4, 2'd0, 32'h0, rd);
      chk("R5", rd, {24'hFFFFFF, 8'hA0 + r0});
      chk("R5", stb_cyc - sc0, 4);
      acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
      chk("R5", rd, 32'hFFFFFF78);
      dly = 0;

      // R12 reset during a hanging cycle
      acc(1'b1, 3'd2, 2'd0, 32'h04, rd);
      ack_limit = acked;
      acc(1'b1, 3'd3, 2'd0, 32'h01, rd);
      tmo_limit = 16'd1000;
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_off = 3'd3; host_size = 2'd0; host_wdata = 32'h10;
      @(negedge clk);
      host_req = 1'b0;
      repeat (5) @(negedge clk);
      chk("R5", {22'h0, addr_stb, xfer_wr, pd_oe, pd_out}, {22'h0, 3'b111, 8'h10});
      rst_n = 1'b0;
      @(negedge clk);
      chk("R12", {29'h0, addr_stb, data_stb, host_busy}, 32'h0);
      rst_n = 1'b1;
      acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
      chk("R12", rd, 32'hFFFFFF78);
      acc(1'b0, 3'd2, 2'd0, 32'h0, rd);
      chk("R12", rd, 32'hFFFFFFCC);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule